// File: doc/BRIEF.md
# Synchronous Byte-Lane Static Memory

This block is a clocked static memory whose word is split into four 9-bit lanes. Each lane holds eight data bits and one parity bit. The address, the write word, the chip select, the cycle strobe, the four lane write strobes and the all-lanes write strobe are all sampled on the rising clock edge. A new access begins only on an edge where the cycle strobe is low. On that edge the block either latches the address and opens a session, or, when the chip select is high, closes the session. While the strobe is high, each edge continues the open session at the held address. On each such edge the write strobes of that edge decide whether the edge reads or writes.

Reads are flow-through. The word at the held address appears combinationally in the cycle that follows the edge that set up the access, with no extra pipeline stage. The output enable is never sampled by the clock. It gates the read drive directly, and a write cycle never drives the bus. The bidirectional bus is split into a write-data input, a read-data output and a drive-enable output. A pad wrapper turns these three into a tri-state bus.

Top module: `sbw_sram`

## Requirements
- R1: After reset the block is deselected: `drive_o` is 0 and `rdata_o` is 0 until a cycle is started with `cyc_n_i` low and `sel_n_i` low.
- R2: An edge with `cyc_n_i`=0 and `sel_n_i`=1 deselects the block. `drive_o` is 0 in the following cycle. Later edges with `cyc_n_i`=1 neither drive nor write, whatever the write strobes are.
- R3: An edge with `cyc_n_i`=0, `sel_n_i`=0 and no write strobe low latches `addr_i` and starts a read. With `oe_n_i`=0, the stored word is on `rdata_o` with `drive_o`=1 in the cycle right after that edge.
- R4: On an edge with `cyc_n_i`=1, an open session continues at the held address. `addr_i` and `sel_n_i` have no effect on that edge.
- R5: An edge is a write when any bit of `lane_we_n_i` is 0 or `all_we_n_i` is 0. Lane k occupies word bits [9k+8:9k], with the parity bit at 9k+8, and `lane_we_n_i[k]`=0 writes it.
- R6: In a write where `all_we_n_i`=1, lanes whose strobe bit is 1 keep their earlier contents.
- R7: `all_we_n_i`=0 writes all four lanes, whatever the value of `lane_we_n_i`.
- R8: In the cycle after a write edge, `drive_o` is 0 even when `oe_n_i` is 0.
- R9: `oe_n_i` acts without a clock edge. In a read cycle, lowering it raises `drive_o` and raising it clears `drive_o` within the same cycle.
- R10: Whenever `drive_o` is 0, `rdata_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the cycle state |
| addr_i | input | ADDR_W | Word address, latched only when a cycle starts |
| wdata_i | input | 36 | Write word, four 9-bit lanes |
| sel_n_i | input | 1 | Active-low chip select, sampled only when a cycle starts |
| cyc_n_i | input | 1 | Active-low cycle strobe: start (low) or continue (high) |
| lane_we_n_i | input | 4 | Active-low write strobe per lane |
| all_we_n_i | input | 1 | Active-low write of every lane |
| oe_n_i | input | 1 | Active-low asynchronous output enable |
| rdata_o | output | 36 | Read word, zero when not driving |
| drive_o | output | 1 | Bus drive enable for the pad wrapper |

## Verification
The assertions assume that reset is applied before the first strobe and that every input is stable around the rising edge. They also assume that `oe_n_i` changes only away from that edge. The bench changes all inputs one time unit after the falling edge and samples at the falling edge. It reads back only addresses it has already written, so that every expected word is defined. It also observes the drive enable as a separate signal rather than resolving a shared bus.

// File: rtl/sbw_pkg.sv
package sbw_pkg;

  typedef enum logic [1:0] {
    CK_HOLD  = 2'd0,  // strobe high with no open session
    CK_DESEL = 2'd1,  // strobe low, select high
    CK_START = 2'd2,  // strobe low, select low
    CK_CONT  = 2'd3   // strobe high, session open
  } cyc_kind_t;

  function automatic cyc_kind_t classify(input logic cyc_n, input logic sel_n,
                                         input logic open_q);
    if (!cyc_n) return sel_n ? CK_DESEL : CK_START;
    return open_q ? CK_CONT : CK_HOLD;
  endfunction

endpackage

// File: rtl/sbw_cycle_ctrl.sv
module sbw_cycle_ctrl #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_n,
  input  logic              sel_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  lane_we_n,
  input  logic              all_we_n,
  output logic              open_q,
  output logic              wr_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              st_we,
  output logic [ADDR_W-1:0] st_addr,
  output logic [LANES-1:0]  st_lanes
);
  import sbw_pkg::*;

  function automatic logic [LANES-1:0] lanes_of(input logic [LANES-1:0] lw_n,
                                                input logic aw_n);
    return aw_n ? ~lw_n : {LANES{1'b1}};
  endfunction

  cyc_kind_t kind;
  logic      wr_req;
  logic      fire_start;
  logic      fire_desel;

  assign kind       = classify(cyc_n, sel_n, open_q);
  assign wr_req     = (lane_we_n != {LANES{1'b1}}) || !all_we_n;
  assign fire_start = (kind == CK_START);
  assign fire_desel = (kind == CK_DESEL);

  assign st_we    = wr_req && (fire_start || kind == CK_CONT);
  assign st_addr  = fire_start ? addr : addr_q;
  assign st_lanes = lanes_of(lane_we_n, all_we_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      wr_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      unique case (kind)
        CK_START: begin
          open_q <= 1'b1;
          wr_q   <= wr_req;
          addr_q <= addr;
        end
        CK_DESEL: begin
          open_q <= 1'b0;
          wr_q   <= 1'b0;
        end
        CK_CONT:  wr_q <= wr_req;
        default:  wr_q <= 1'b0;
      endcase
    end
  end

  p_desel_closes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fire_desel |=> !open_q);

  p_addr_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_n |=> $stable(addr_q));

  p_sel_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_n |=> (open_q == $past(open_q)));

  p_global_all_lanes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_we && !all_we_n) |-> (st_lanes == {LANES{1'b1}}));

endmodule

// File: rtl/sbw_lane_store.sv
module sbw_lane_store #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES-1:0]        lanes,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [LANES*LANE_W-1:0] rd_word
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
      if (we && lanes[g]) cells[wr_addr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rd_word[g*LANE_W +: LANE_W] = cells[rd_addr];
  end

endmodule

// File: rtl/sbw_sram.sv
module sbw_sram #(
  parameter int ADDR_W     = 8,
  parameter int LANES      = 4,
  parameter int LANE_DBITS = 8
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [ADDR_W-1:0]                     addr_i,
  input  logic [LANES*(LANE_DBITS+1)-1:0]       wdata_i,
  input  logic                                  sel_n_i,
  input  logic                                  cyc_n_i,
  input  logic [LANES-1:0]                      lane_we_n_i,
  input  logic                                  all_we_n_i,
  input  logic                                  oe_n_i,
  output logic [LANES*(LANE_DBITS+1)-1:0]       rdata_o,
  output logic                                  drive_o
);
  localparam int LANE_W = LANE_DBITS + 1;
  localparam int WORD_W = LANES * LANE_W;

  logic              open_q;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic              st_we;
  logic [ADDR_W-1:0] st_addr;
  logic [LANES-1:0]  st_lanes;
  logic [WORD_W-1:0] rd_word;
  logic              read_phase;

  sbw_cycle_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cyc_n(cyc_n_i), .sel_n(sel_n_i),
    .addr(addr_i), .lane_we_n(lane_we_n_i), .all_we_n(all_we_n_i),
    .open_q(open_q), .wr_q(wr_q), .addr_q(addr_q),
    .st_we(st_we), .st_addr(st_addr), .st_lanes(st_lanes)
  );

  sbw_lane_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
    .clk(clk), .we(st_we), .wr_addr(st_addr), .lanes(st_lanes),
    .wdata(wdata_i), .rd_addr(addr_q), .rd_word(rd_word)
  );

  assign read_phase = open_q && !wr_q;
  assign drive_o    = read_phase && !oe_n_i;
  assign rdata_o    = drive_o ? rd_word : '0;

  p_quiet_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    st_we |=> !drive_o);

  p_quiet_after_desel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc_n_i && sel_n_i) |=> !drive_o);

  p_zero_when_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_o |-> (rdata_o == '0));

  p_drive_needs_oe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n_i |-> !drive_o);

endmodule

// File: tb/sbw_sram_test.sv
module sbw_sram_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [35:0] wdata_i = '0;
  logic        sel_n_i = 1'b1;
  logic        cyc_n_i = 1'b1;
  logic [3:0]  lane_we_n_i = 4'hF;
  logic        all_we_n_i = 1'b1;
  logic        oe_n_i = 1'b1;
  logic [35:0] rdata_o;
  logic        drive_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  sbw_sram uut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wdata_i(wdata_i),
    .sel_n_i(sel_n_i), .cyc_n_i(cyc_n_i), .lane_we_n_i(lane_we_n_i),
    .all_we_n_i(all_we_n_i), .oe_n_i(oe_n_i), .rdata_o(rdata_o),
    .drive_o(drive_o)
  );

  always #5 clk = ~clk;

  // reference state
  logic [35:0] ref_mem [256];
  bit          ref_open = 0;
  bit          ref_wr = 0;
  logic [7:0]  ref_addr = '0;

  bit          q_drv [$];
  logic [35:0] q_dat [$];
  string       q_req [$];

  task automatic check(input string req, input bit d, input logic [35:0] dat,
                       input bit ed, input logic [35:0] edat);
    checks++;
    if (d !== ed || dat !== edat) begin
      failures++;
      $display("FAIL %s: drive=%0b data=%h expected drive=%0b data=%h",
               req, d, dat, ed, edat);
    end
  endtask

  // driver: one clock edge of stimulus, pushes the expected outcome
  task automatic cyc(input bit cn, input bit sn, input logic [7:0] a,
                     input logic [35:0] wd, input logic [3:0] lw,
                     input bit aw, input bit oe, input string req);
    bit wr;
    bit ed;
    @(negedge clk);
    #1;
    cyc_n_i = cn; sel_n_i = sn; addr_i = a; wdata_i = wd;
    lane_we_n_i = lw; all_we_n_i = aw; oe_n_i = oe;
    wr = (lw != 4'hF) || !aw;
    if (!cn) begin
      if (sn) begin ref_open = 0; ref_wr = 0; end
      else begin ref_open = 1; ref_addr = a; ref_wr = wr; end
    end else if (ref_open) ref_wr = wr;
    else ref_wr = 0;
    if (ref_open && ref_wr)
      for (int k = 0; k < 4; k++)
        if (!aw || !lw[k]) ref_mem[ref_addr][9*k +: 9] = wd[9*k +: 9];
    @(posedge clk);
    #1;
    ed = ref_open && !ref_wr && !oe;
    q_drv.push_back(ed);
    q_dat.push_back(ed ? ref_mem[ref_addr] : 36'h0);
    q_req.push_back(req);
  endtask

  // monitor: compares at the falling edge
  always @(negedge clk) begin
    if (q_drv.size() > 0) begin
      bit ed;
      logic [35:0] edat;
      string rq;
      ed = q_drv.pop_front();
      edat = q_dat.pop_front();
      rq = q_req.pop_front();
      check(rq, drive_o, rdata_o, ed, edat);
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset", drive_o, rdata_o, 1'b0, 36'h0);

    // R7 + R8: global write at 5 with lane strobes idle, oe low
    cyc(0, 0, 8'd5, 36'h1_2345_6789, 4'hF, 0, 0, "R8 write quiet");
    // R4 + R5: continue write at held 5, addr/sel wiggle, lane 1 only
    cyc(1, 1, 8'd77, 36'hA_BCDE_F012, 4'b1101, 1, 0, "R5 lane1 write");
    // R3 + R6: read 5 back
    cyc(0, 0, 8'd5, 36'h0, 4'hF, 1, 0, "R6 masked read");
    // R7: global overrides partial lane strobes
    cyc(0, 0, 8'd9, 36'hF_0F0F_0F0F, 4'b1110, 0, 1, "R7 global write");
    cyc(0, 0, 8'd9, 36'h0, 4'hF, 1, 0, "R7 read all lanes");
    // R4: continue read, addr and select ignored
    cyc(1, 1, 8'd5, 36'h0, 4'hF, 1, 0, "R4 held read");
    // R5: parity lane bit only via lane 3
    cyc(0, 0, 8'd9, 36'h8_0000_0000, 4'b0111, 1, 0, "R5 lane3 write");
    cyc(1, 0, 8'd0, 36'h0, 4'hF, 1, 0, "R5 lane3 read");
    // R3 with oe high: no drive, R10 zeros
    cyc(0, 0, 8'd5, 36'h0, 4'hF, 1, 1, "R10 oe high");
    // R9: async output enable within the same cycle
    @(negedge clk);
    #1 oe_n_i = 1'b0;
    #1 check("R9 oe low", drive_o, rdata_o, 1'b1, ref_mem[5]);
    #1 oe_n_i = 1'b1;
    #1 check("R9 oe high", drive_o, rdata_o, 1'b0, 36'h0);
    // R2: deselect, then continue with strobes low -> no write
    cyc(0, 1, 8'd9, 36'h0, 4'hF, 1, 0, "R2 deselect");
    cyc(1, 0, 8'd9, 36'h3_3333_3333, 4'h0, 0, 0, "R2 no write");
    cyc(1, 0, 8'd9, 36'h0, 4'hF, 1, 0, "R2 still idle");
    cyc(0, 0, 8'd9, 36'h0, 4'hF, 1, 0, "R2 word kept");
    // R8: write continuation of a read session
    cyc(1, 1, 8'd1, 36'h0_0000_0055, 4'b1110, 1, 0, "R8 cont write");
    cyc(1, 1, 8'd1, 36'h0, 4'hF, 1, 0, "R6 after cont");
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule